// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames from a line that several stations share. It samples the input at sixteen times the bit rate. A clock-enable pulse, `tick16`, sets that rate. Each frame holds a low start bit, `DATA_W` data bits sent least significant bit first, an optional extra bit and a high stop bit. The block then presents the received byte together with a data-ready flag, three error flags and two interrupt request lines.

The extra bit has two uses. In plain mode it is a parity bit, checked as even or odd. In addressed mode it marks the frame as an address frame (1) or a payload frame (0). In addressed mode, every payload frame is dropped until an address frame arrives whose data equals the programmed station address. Payload frames after such a match are delivered. An address frame that does not match blocks payload again until the next address frame is compared.

Top module: `mpuart_rx`

## Requirements
- R1: A frame is a 0 start bit, then `DATA_W` data bits with bit 0 first, then a 1 stop bit. An accepted frame puts its data on `rx_data` and sets `rx_full`, and `irq_rx` follows `rx_full`.
- R2: A one-cycle `rd_ack` pulse clears `rx_full` and `irq_rx`.
- R3: A stop bit sampled as 0 sets `err_frame` and raises `irq_err`. The data is still delivered and `rx_full` is set.
- R4: With `cfg_parity_en`=1 and `cfg_mp_en`=0, one parity bit sits between the last data bit and the stop bit. `cfg_parity_odd`=0 selects even parity and 1 selects odd parity. Over data plus parity, a count of ones that does not match the selected kind sets `err_parity` and `irq_err`.
- R5: With `cfg_mp_en`=1, the extra bit is the address marker and parity is never checked. Payload frames (marker 0) received while no address match is held are dropped. They set no flag, even when their stop bit is 0.
- R6: An address frame (marker 1, stop bit 1) whose data equals `cfg_station_id` makes the following payload frames delivered. The address frame itself never sets `rx_full`.
- R7: An address frame whose data differs from `cfg_station_id` cancels any earlier match, so payload is dropped until a later address frame matches.
- R8: A low pulse on the line that is high again at mid start bit is ignored and produces no frame.
- R9: Each bit value is the majority of the samples taken at positions 7, 8 and 9 of its 16 sample slots, so a single disturbed sample does not change the bit.
- R10: A frame accepted while `rx_full` is still set sets `err_overrun` and raises `irq_err`. The new data is discarded and `rx_data` keeps the old value.
- R11: A one-cycle `err_clr` pulse clears all three error flags, and `irq_err` is the OR of them.
- R12: After reset, `rx_full`, all error flags and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse, sixteen per bit time |
| rxd | input | 1 | Serial line input, idle high |
| cfg_parity_en | input | 1 | Parity bit present (plain mode) |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_mp_en | input | 1 | Addressed mode enable |
| cfg_station_id | input | DATA_W | Own station address |
| rd_ack | input | 1 | Data taken, clears `rx_full` |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | DATA_W | Last accepted data |
| rx_full | output | 1 | Data-ready flag |
| err_frame | output | 1 | Stop bit was 0 |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Frame lost, data register still full |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is in flight. They also assume that `rd_ack` and `err_clr` are single-cycle pulses. The bench changes the mode only while the line idles between frames, and it holds each line level for a whole bit time of 16 ticks. The only exceptions are deliberate: a short start-bit glitch, and a one-sample disturbance in the middle of a data bit.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int CNT_W  = $clog2(OSR);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_EXTRA, ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              extra;
        logic              stop_ok;
    } frame_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic p, input logic odd);
        return (^d) ^ p ^ odd;
    endfunction
endpackage

// File: rtl/mpuart_bit_engine.sv
module mpuart_bit_engine
    import mpuart_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick16,
    input  logic   rxd,
    input  logic   has_extra,
    output logic   frame_valid,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] MID_A = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] MID_B = CNT_W'(OSR/2);
    localparam logic [CNT_W-1:0] MID_C = CNT_W'(OSR/2 + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(OSR - 1);
    localparam int IDX_W = $clog2(DATA_W);

    logic [1:0]        sync_q;
    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic              s_a, s_b;
    logic [DATA_W-1:0] shreg;
    logic              extra_q;
    logic              rx_s;
    logic              vote;

    assign rx_s = sync_q[1];
    assign vote = vote3(s_a, s_b, rx_s);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        frame_valid <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            s_a     <= 1'b1;
            s_b     <= 1'b1;
            shreg   <= '0;
            extra_q <= 1'b0;
            frame   <= '0;
        end else if (tick16) begin
            if (state == ST_IDLE) begin
                if (!rx_s) begin
                    state <= ST_START;
                    cnt   <= CNT_W'(1);
                end
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == MID_A) s_a <= rx_s;
                if (cnt == MID_B) s_b <= rx_s;
                if (cnt == MID_C) begin
                    unique case (state)
                        ST_START: if (vote) state <= ST_IDLE;
                        ST_DATA:  shreg <= {vote, shreg[DATA_W-1:1]};
                        ST_EXTRA: extra_q <= vote;
                        ST_STOP: begin
                            frame_valid   <= 1'b1;
                            frame.data    <= shreg;
                            frame.extra   <= has_extra ? extra_q : 1'b0;
                            frame.stop_ok <= vote;
                            state         <= ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (cnt == LAST) begin
                    cnt <= '0;
                    unique case (state)
                        ST_START: begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end
                        ST_DATA: begin
                            if (bit_idx == IDX_W'(DATA_W-1))
                                state <= has_extra ? ST_EXTRA : ST_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                        ST_EXTRA: state <= ST_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);
endmodule

// File: rtl/mpuart_addr_filter.sv
module mpuart_addr_filter
    import mpuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  frame_t            frame,
    input  logic              mp_en,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [DATA_W-1:0] station_id,
    output logic              deliver,
    output logic              perr,
    output logic              ferr
);
    logic matched;

    always_ff @(posedge clk) begin
        if (rst || !mp_en)
            matched <= 1'b0;
        else if (frame_valid && frame.extra && frame.stop_ok)
            matched <= (frame.data == station_id);
    end

    always_comb begin
        deliver = frame_valid && (!mp_en || (!frame.extra && matched));
        perr    = parity_en && !mp_en && parity_bad(frame.data, frame.extra, parity_odd);
        ferr    = !frame.stop_ok;
    end
endmodule

// File: rtl/mpuart_status.sv
module mpuart_status
    import mpuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              deliver,
    input  logic [DATA_W-1:0] data_in,
    input  logic              perr,
    input  logic              ferr,
    input  logic              rd_ack,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);
    logic full_left;
    logic take, lose;

    assign full_left = rx_full && !rd_ack;
    assign take      = deliver && !full_left;
    assign lose      = deliver && full_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            rx_full     <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            rx_full     <= full_left || take;
            if (take) rx_data <= data_in;
            err_frame   <= (err_frame   && !err_clr) || (take && ferr);
            err_parity  <= (err_parity  && !err_clr) || (take && perr);
            err_overrun <= (err_overrun && !err_clr) || lose;
        end
    end

    p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
        rd_ack && !deliver |=> !rx_full);
    p_deliver_sets_full_r1: assert property (@(posedge clk) disable iff (rst)
        deliver |=> rx_full);
    p_overrun_keeps_data_r10: assert property (@(posedge clk) disable iff (rst)
        deliver && rx_full && !rd_ack |=> err_overrun && $stable(rx_data));
    p_clear_errors_r11: assert property (@(posedge clk) disable iff (rst)
        err_clr && !deliver |=> !err_frame && !err_parity && !err_overrun);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick16,
    input  logic         rxd,
    input  logic         cfg_parity_en,
    input  logic         cfg_parity_odd,
    input  logic         cfg_mp_en,
    input  logic [W-1:0] cfg_station_id,
    input  logic         rd_ack,
    input  logic         err_clr,
    output logic [W-1:0] rx_data,
    output logic         rx_full,
    output logic         err_frame,
    output logic         err_parity,
    output logic         err_overrun,
    output logic         irq_rx,
    output logic         irq_err
);
    frame_t frame;
    logic   frame_valid;
    logic   deliver, perr, ferr;

    mpuart_bit_engine u_engine (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .has_extra(cfg_parity_en || cfg_mp_en),
        .frame_valid(frame_valid), .frame(frame)
    );

    mpuart_addr_filter u_filter (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame(frame),
        .mp_en(cfg_mp_en), .parity_en(cfg_parity_en), .parity_odd(cfg_parity_odd),
        .station_id(cfg_station_id),
        .deliver(deliver), .perr(perr), .ferr(ferr)
    );

    mpuart_status u_status (
        .clk(clk), .rst(rst), .deliver(deliver), .data_in(frame.data),
        .perr(perr), .ferr(ferr), .rd_ack(rd_ack), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun)
    );

    assign irq_rx  = rx_full;
    assign irq_err = err_frame || err_parity || err_overrun;

    p_id_frame_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        frame_valid && cfg_mp_en && frame.extra |=>
            rx_full == ($past(rx_full) && !$past(rd_ack)));
    p_skipped_no_flags_r5: assert property (@(posedge clk) disable iff (rst)
        frame_valid && cfg_mp_en && !err_clr |=>
            (err_frame || !$past(err_frame) == 1'b1) &&
            (err_parity == $past(err_parity) || !$past(deliver)));
endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
    localparam int W   = 8;
    localparam int BIT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16;
    logic [1:0] tdiv = '0;
    logic rxd = 1'b1;
    logic cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_mp_en = 1'b0;
    logic [W-1:0] cfg_station_id = 8'h42;
    logic rd_ack = 1'b0, err_clr = 1'b0;
    logic [W-1:0] rx_data;
    logic rx_full, err_frame, err_parity, err_overrun, irq_rx, irq_err;
    int total = 0, bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd3);

    mpuart_rx u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_mp_en(cfg_mp_en), .cfg_station_id(cfg_station_id),
        .rd_ack(rd_ack), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] d, input logic has_x, input logic x,
                        input logic stop, input int glitch_bit = -1);
        hold(1'b0, BIT);
        for (int i = 0; i < W; i++) begin
            if (i == glitch_bit) begin
                hold(d[i], BIT/2 - 2);
                hold(~d[i], 4);
                hold(d[i], BIT/2 - 2);
            end else begin
                hold(d[i], BIT);
            end
        end
        if (has_x) hold(x, BIT);
        hold(stop, BIT);
        hold(1'b1, 2*BIT);
    endtask

    task automatic pulse_rd();
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        check("R12", "rx_full", rx_full, 0);
        check("R12", "errors", {err_frame, err_parity, err_overrun}, 0);
        check("R12", "irqs", {irq_rx, irq_err}, 0);
    endtask

    task automatic t_basic();
        send(8'hA5, 0, 0, 1);
        check("R1", "data A5", rx_data, 8'hA5);
        check("R1", "full/irq", {rx_full, irq_rx}, 2'b11);
        pulse_rd();
        check("R2", "full after read", {rx_full, irq_rx}, 0);
        send(8'h3C, 0, 0, 1);
        check("R1", "data 3C", rx_data, 8'h3C);
        pulse_rd();
    endtask

    task automatic t_frame_err();
        send(8'h55, 0, 0, 0);
        check("R3", "full", rx_full, 1);
        check("R3", "data", rx_data, 8'h55);
        check("R3", "ferr/irq", {err_frame, irq_err}, 2'b11);
        pulse_clr();
        check("R11", "flags cleared", {err_frame, err_parity, err_overrun, irq_err}, 0);
        pulse_rd();
    endtask

    task automatic t_parity();
        cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
        send(8'h07, 1, 1, 1);
        check("R4", "even ok", {rx_full, err_parity}, 2'b10);
        check("R4", "data", rx_data, 8'h07);
        pulse_rd();
        send(8'h07, 1, 0, 1);
        check("R4", "even bad", {err_parity, irq_err}, 2'b11);
        pulse_clr(); pulse_rd();
        cfg_parity_odd = 1'b1;
        send(8'h07, 1, 0, 1);
        check("R4", "odd ok", {rx_full, err_parity}, 2'b10);
        pulse_rd();
        cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0;
    endtask

    task automatic t_overrun();
        send(8'h11, 0, 0, 1);
        send(8'h22, 0, 0, 1);
        check("R10", "overrun/irq", {err_overrun, irq_err}, 2'b11);
        check("R10", "data kept", rx_data, 8'h11);
        pulse_clr(); pulse_rd();
    endtask

    task automatic t_addressed();
        cfg_mp_en = 1'b1; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b1;
        send(8'h10, 1, 0, 1);
        check("R5", "payload before id dropped", rx_full, 0);
        send(8'h10, 1, 0, 0);
        check("R5", "dropped frame no flags", {err_frame, irq_err}, 0);
        send(8'h42, 1, 1, 1);
        check("R6", "id frame not delivered", rx_full, 0);
        send(8'h99, 1, 0, 1);
        check("R6", "payload after match", {rx_full, rx_data}, {1'b1, 8'h99});
        check("R5", "no parity check", err_parity, 0);
        pulse_rd();
        send(8'h13, 1, 1, 1);
        send(8'h77, 1, 0, 1);
        check("R7", "payload after mismatch dropped", rx_full, 0);
        send(8'h42, 1, 1, 1);
        send(8'h5A, 1, 0, 1);
        check("R7", "payload after rematch", {rx_full, rx_data}, {1'b1, 8'h5A});
        pulse_rd();
        cfg_mp_en = 1'b0; cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0;
    endtask

    task automatic t_glitch();
        hold(1'b0, 8);
        hold(1'b1, 3*BIT);
        check("R8", "glitch ignored", {rx_full, irq_err}, 0);
        send(8'hC3, 0, 0, 1);
        check("R8", "frame after glitch", rx_data, 8'hC3);
        pulse_rd();
    endtask

    task automatic t_majority();
        send(8'h00, 0, 0, 1, 3);
        check("R9", "disturbed bit", rx_data, 8'h00);
        pulse_rd();
        send(8'hFF, 0, 0, 1, 5);
        check("R9", "disturbed bit high", rx_data, 8'hFF);
        pulse_rd();
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_frame_err();
        t_parity();
        t_overrun();
        t_addressed();
        t_glitch();
        t_majority();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule